// File: doc/BRIEF.md
# Hierarchical Alarm Status Aggregator

This block gathers live alarm conditions from a thermal monitor (per-channel high limit, low limit, remote diode fault and critical temperature, plus fan and general-purpose input alarms) into sticky second-level status registers. Each second-level register is summarised into one bit of a top-level interrupt status byte. An active-low alert output is pulled low while any unmasked status bit is set. A separate shutdown output follows the live critical-temperature condition of the channels that are associated with shutdown.

Software reads the registers through a simple port with a read strobe, an address and registered read data. Reading a second-level register returns its value before the clear. The same read clears only those bits whose condition has since gone away. Reading the top-level byte clears nothing. A summary bit drops only once its second-level register has been read and emptied.

Top module: `alarm_status_agg`

## Requirements
- R1: Address map (3-bit read address): 0 top-level status, 1 critical, 2 high, 3 low, 4 diode fault, 5 fan, 6 GPIO; address 7 reads 00h.
- R2: Top-level status byte: bit 0 is the OR of the diode-fault register, bit 1 of the low register, bit 2 of the high register, bit 3 of the fan register, bit 4 of the GPIO register and bit 5 of the critical channel bits. Bits 7:6 read 0.
- R3: The high, low and diode-fault registers hold one bit per channel: bit 0 internal, bits 1 to 3 external 1 to 3. The internal channel's diode-fault bit always reads 0. All registers read 00h after reset.
- R4: A status bit becomes set on the clock edge where its condition is sampled high. It then stays set, whatever the condition does, until its register is read.
- R5: A read of a second-level register clears each bit whose condition is low in the strobe cycle. A bit whose condition is high in that cycle stays set, including a condition that first rises in that very cycle.
- R6: A read of the top-level status byte leaves every second-level bit unchanged.
- R7: Read data is captured on the strobe's clock edge and holds the register value from before that edge's clear.
- R8: The alert output is low in the cycle after any unmasked status bit is set. It is high in the cycle after no unmasked bit remains.
- R9: A set channel mask bit does not stop that channel's high, low, fault and critical bits from being set and read, but those bits do not pull the alert output low. Fan and GPIO bits have their own per-bit masks that work the same way.
- R10: Bit 7 of the critical register reads 1 while the shutdown output is asserted. This flag never pulls the alert output low.
- R11: The shutdown output is registered. In the cycle after an edge, it equals the OR of the critical conditions of shutdown-enabled channels sampled at that edge. A channel's critical status bit, once set, stays set after its condition falls, until it is read.
- R12: A channel whose shutdown enable is low never sets its critical status bit and never asserts the shutdown output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cond_i | input | NCH | Live high-limit condition per channel |
| lo_cond_i | input | NCH | Live low-limit condition per channel |
| flt_cond_i | input | NCH | Live diode-fault condition per channel (bit 0 ignored) |
| crit_cond_i | input | NCH | Live critical-temperature condition per channel |
| fan_cond_i | input | NFAN | Live fan alarm per fan |
| gpio_cond_i | input | NGPIO | Live GPIO alarm per input |
| shdn_en_i | input | NCH | Per-channel shutdown association |
| ch_mask_i | input | NCH | Per-channel alert mask (1 = masked) |
| fan_mask_i | input | NFAN | Per-fan alert mask |
| gpio_mask_i | input | NGPIO | Per-GPIO alert mask |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 3 | Register address |
| rd_data_o | output | 8 | Registered read data |
| alert_n_o | output | 1 | Active-low alert |
| shutdown_o | output | 1 | Critical-temperature shutdown, active high |

## Verification
The hardest case is a condition that rises in exactly the cycle whose read would otherwise clear its bit. The bench makes a bit stale by letting its condition fall. It then raises the condition for one cycle together with the read strobe and drops it again. It checks that the next read still sees the bit, and that only the read after that empties it. A second awkward case is a shutdown that is active while its channel is masked. The bench reaches it by enabling shutdown on a masked channel. The hardware-shutdown flag then reads 1 while the alert output stays released.

// File: rtl/alarm_status_pkg.sv
package alarm_status_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SUMMARY = 3'd0,
    REG_CRIT    = 3'd1,
    REG_HIGH    = 3'd2,
    REG_LOW     = 3'd3,
    REG_FAULT   = 3'd4,
    REG_FAN     = 3'd5,
    REG_GPIO    = 3'd6
  } reg_addr_e;

  localparam int unsigned SUM_FAULT = 0;
  localparam int unsigned SUM_LOW   = 1;
  localparam int unsigned SUM_HIGH  = 2;
  localparam int unsigned SUM_FAN   = 3;
  localparam int unsigned SUM_GPIO  = 4;
  localparam int unsigned SUM_CRIT  = 5;
  localparam int unsigned HWS_BIT   = 7;
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned NB = 4,
  parameter logic [NB-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic          clr_i,
  output logic [NB-1:0] q_o
);
  // A live condition always wins over a clearing read.
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= ((clr_i ? '0 : q_o) | set_i) & VALID;
  end
endmodule

// File: rtl/alert_gen.sv
module alert_gen #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned NFAN  = 2,
  parameter int unsigned NGPIO = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   hi_q_i,
  input  logic [NCH-1:0]   lo_q_i,
  input  logic [NCH-1:0]   flt_q_i,
  input  logic [NCH-1:0]   crit_q_i,
  input  logic [NFAN-1:0]  fan_q_i,
  input  logic [NGPIO-1:0] gpio_q_i,
  input  logic [NCH-1:0]   ch_mask_i,
  input  logic [NFAN-1:0]  fan_mask_i,
  input  logic [NGPIO-1:0] gpio_mask_i,
  output logic             alert_n_o
);
  logic [NCH-1:0] ch_any;
  logic           any_live;

  always_comb begin
    ch_any   = (hi_q_i | lo_q_i | flt_q_i | crit_q_i) & ~ch_mask_i;
    any_live = (|ch_any) | (|(fan_q_i & ~fan_mask_i)) | (|(gpio_q_i & ~gpio_mask_i));
  end

  always_ff @(posedge clk) begin
    if (rst) alert_n_o <= 1'b1;
    else     alert_n_o <= ~any_live;
  end
endmodule

// File: rtl/alarm_status_agg.sv
module alarm_status_agg
  import alarm_status_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned NFAN  = 2,
  parameter int unsigned NGPIO = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    hi_cond_i,
  input  logic [NCH-1:0]    lo_cond_i,
  input  logic [NCH-1:0]    flt_cond_i,
  input  logic [NCH-1:0]    crit_cond_i,
  input  logic [NFAN-1:0]   fan_cond_i,
  input  logic [NGPIO-1:0]  gpio_cond_i,
  input  logic [NCH-1:0]    shdn_en_i,
  input  logic [NCH-1:0]    ch_mask_i,
  input  logic [NFAN-1:0]   fan_mask_i,
  input  logic [NGPIO-1:0]  gpio_mask_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alert_n_o,
  output logic              shutdown_o
);
  // Internal channel (bit 0) has no remote diode.
  localparam logic [NCH-1:0] FLT_VALID = {{(NCH-1){1'b1}}, 1'b0};

  logic [NCH-1:0]   hi_q, lo_q, flt_q, crit_q, crit_set;
  logic [NFAN-1:0]  fan_q;
  logic [NGPIO-1:0] gpio_q;
  logic             clr_hi, clr_lo, clr_flt, clr_crit, clr_fan, clr_gpio;
  logic [DATA_W-1:0] summary;

  always_comb begin
    clr_hi   = rd_en_i && (rd_addr_i == REG_HIGH);
    clr_lo   = rd_en_i && (rd_addr_i == REG_LOW);
    clr_flt  = rd_en_i && (rd_addr_i == REG_FAULT);
    clr_crit = rd_en_i && (rd_addr_i == REG_CRIT);
    clr_fan  = rd_en_i && (rd_addr_i == REG_FAN);
    clr_gpio = rd_en_i && (rd_addr_i == REG_GPIO);
    crit_set = crit_cond_i & shdn_en_i;
  end

  sticky_bank #(.NB(NCH)) u_hi (
    .clk(clk), .rst(rst), .set_i(hi_cond_i), .clr_i(clr_hi), .q_o(hi_q));
  sticky_bank #(.NB(NCH)) u_lo (
    .clk(clk), .rst(rst), .set_i(lo_cond_i), .clr_i(clr_lo), .q_o(lo_q));
  sticky_bank #(.NB(NCH), .VALID(FLT_VALID)) u_flt (
    .clk(clk), .rst(rst), .set_i(flt_cond_i), .clr_i(clr_flt), .q_o(flt_q));
  sticky_bank #(.NB(NCH)) u_crit (
    .clk(clk), .rst(rst), .set_i(crit_set), .clr_i(clr_crit), .q_o(crit_q));
  sticky_bank #(.NB(NFAN)) u_fan (
    .clk(clk), .rst(rst), .set_i(fan_cond_i), .clr_i(clr_fan), .q_o(fan_q));
  sticky_bank #(.NB(NGPIO)) u_gpio (
    .clk(clk), .rst(rst), .set_i(gpio_cond_i), .clr_i(clr_gpio), .q_o(gpio_q));

  alert_gen #(.NCH(NCH), .NFAN(NFAN), .NGPIO(NGPIO)) u_alert (
    .clk(clk), .rst(rst),
    .hi_q_i(hi_q), .lo_q_i(lo_q), .flt_q_i(flt_q), .crit_q_i(crit_q),
    .fan_q_i(fan_q), .gpio_q_i(gpio_q),
    .ch_mask_i(ch_mask_i), .fan_mask_i(fan_mask_i), .gpio_mask_i(gpio_mask_i),
    .alert_n_o(alert_n_o));

  always_ff @(posedge clk) begin
    if (rst) shutdown_o <= 1'b0;
    else     shutdown_o <= |crit_set;
  end

  always_comb begin
    summary            = '0;
    summary[SUM_FAULT] = |flt_q;
    summary[SUM_LOW]   = |lo_q;
    summary[SUM_HIGH]  = |hi_q;
    summary[SUM_FAN]   = |fan_q;
    summary[SUM_GPIO]  = |gpio_q;
    summary[SUM_CRIT]  = |crit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      case (rd_addr_i)
        REG_SUMMARY: rd_data_o <= summary;
        REG_CRIT: begin
          rd_data_o          <= DATA_W'(crit_q);
          rd_data_o[HWS_BIT] <= shutdown_o;
        end
        REG_HIGH:    rd_data_o <= DATA_W'(hi_q);
        REG_LOW:     rd_data_o <= DATA_W'(lo_q);
        REG_FAULT:   rd_data_o <= DATA_W'(flt_q);
        REG_FAN:     rd_data_o <= DATA_W'(fan_q);
        REG_GPIO:    rd_data_o <= DATA_W'(gpio_q);
        default:     rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/alarm_status_chk.sv
module alarm_status_chk
  import alarm_status_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned NFAN  = 2,
  parameter int unsigned NGPIO = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    hi_cond_i,
  input logic [NCH-1:0]    crit_cond_i,
  input logic [NCH-1:0]    shdn_en_i,
  input logic [NCH-1:0]    ch_mask_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [NCH-1:0]    hi_q,
  input logic [NCH-1:0]    lo_q,
  input logic [NCH-1:0]    flt_q,
  input logic [NCH-1:0]    crit_q,
  input logic [NFAN-1:0]   fan_q,
  input logic [NGPIO-1:0]  gpio_q,
  input logic              alert_n_o,
  input logic              shutdown_o
);
  logic [NCH-1:0] unmasked_ch;
  assign unmasked_ch = (hi_q | lo_q | flt_q | crit_q) & ~ch_mask_i;

  // R4: without a read of the high register no set bit falls
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_i && rd_addr_i == REG_HIGH) |=> ((hi_q & $past(hi_q)) == $past(hi_q)));

  // R5: a live condition always leaves its bit set
  p_cond_wins_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((hi_q & $past(hi_cond_i)) == $past(hi_cond_i)));

  // R8: any unmasked channel bit pulls alert low next cycle
  p_alert_low_r8: assert property (@(posedge clk) disable iff (rst)
    (|unmasked_ch) |=> !alert_n_o);

  // R10: with no unmasked bit the alert stays released, shutdown or not
  p_no_hws_alert_r10: assert property (@(posedge clk) disable iff (rst)
    (unmasked_ch == '0 && fan_q == '0 && gpio_q == '0) |=> alert_n_o);

  // R11: shutdown tracks the enabled live condition
  p_shdn_track_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (shutdown_o == $past(|(crit_cond_i & shdn_en_i))));

  // R12: a channel without shutdown enable never gains a critical bit
  p_crit_gated_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((crit_q & ~$past(crit_q) & ~$past(crit_cond_i & shdn_en_i)) == '0));
endmodule

bind alarm_status_agg alarm_status_chk #(.NCH(NCH), .NFAN(NFAN), .NGPIO(NGPIO)) u_chk (
  .clk(clk), .rst(rst), .hi_cond_i(hi_cond_i), .crit_cond_i(crit_cond_i),
  .shdn_en_i(shdn_en_i), .ch_mask_i(ch_mask_i), .rd_en_i(rd_en_i),
  .rd_addr_i(rd_addr_i), .hi_q(hi_q), .lo_q(lo_q), .flt_q(flt_q),
  .crit_q(crit_q), .fan_q(fan_q), .gpio_q(gpio_q),
  .alert_n_o(alert_n_o), .shutdown_o(shutdown_o));

// File: tb/tb_alarm_status_agg.sv
module tb_alarm_status_agg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] hi_c = '0, lo_c = '0, flt_c = '0, crit_c = '0;
  logic [1:0] fan_c = '0, fan_m = '0;
  logic [3:0] gpio_c = '0, gpio_m = '0;
  logic [3:0] shdn_en = '0, ch_m = '0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       alert_n, shutdown;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  alarm_status_agg dut (
    .clk(clk), .rst(rst), .hi_cond_i(hi_c), .lo_cond_i(lo_c), .flt_cond_i(flt_c),
    .crit_cond_i(crit_c), .fan_cond_i(fan_c), .gpio_cond_i(gpio_c),
    .shdn_en_i(shdn_en), .ch_mask_i(ch_m), .fan_mask_i(fan_m), .gpio_mask_i(gpio_m),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .alert_n_o(alert_n), .shutdown_o(shutdown));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R3 reset reg", d, 8'h00);
    end
    chk("R8 reset alert", {7'd0, alert_n}, 8'h01);
    chk("R11 reset shutdown", {7'd0, shutdown}, 8'h00);
  endtask

  task automatic t_high_sticky();
    hi_c = 4'b0100; step(1); hi_c = '0; step(1);
    chk("R8 alert low", {7'd0, alert_n}, 8'h00);
    step(3);
    rd(3'd0, d); chk("R2 summary high", d, 8'h04);
    rd(3'd0, d); chk("R6 summary read no clear", d, 8'h04);
    rd(3'd2, d); chk("R7 pre-clear value", d, 8'h04);
    rd(3'd2, d); chk("R5 cleared after read", d, 8'h00);
    rd(3'd0, d); chk("R2 summary drops", d, 8'h00);
    step(1); chk("R8 alert released", {7'd0, alert_n}, 8'h01);
  endtask

  task automatic t_persist();
    lo_c = 4'b0011; step(2);
    rd(3'd3, d); chk("R7 low read", d, 8'h03);
    rd(3'd3, d); chk("R5 persistent survives", d, 8'h03);
    lo_c = 4'b0001; step(1);
    rd(3'd3, d); chk("R5 partial", d, 8'h03);
    rd(3'd3, d); chk("R5 partial clear", d, 8'h01);
    lo_c = '0; rd(3'd3, d); rd(3'd3, d); chk("R5 low empty", d, 8'h00);
  endtask

  task automatic t_race();
    hi_c = 4'b1000; step(1); hi_c = '0; step(1);
    hi_c = 4'b1000; rd_en = 1'b1; rd_addr = 3'd2;
    @(negedge clk); rd_en = 1'b0; hi_c = '0;
    chk("R7 race read", rd_data, 8'h08);
    rd(3'd2, d); chk("R5 race bit kept", d, 8'h08);
    rd(3'd2, d); chk("R5 race then clear", d, 8'h00);
  endtask

  task automatic t_fault();
    flt_c = 4'b1111; step(1); flt_c = '0;
    rd(3'd0, d); chk("R2 summary fault", d, 8'h01);
    rd(3'd4, d); chk("R3 internal fault absent", d, 8'h0E);
    rd(3'd4, d); chk("R5 fault cleared", d, 8'h00);
  endtask

  task automatic t_mask();
    ch_m = 4'b0010; hi_c = 4'b0010; step(1); hi_c = '0; step(2);
    chk("R9 masked no alert", {7'd0, alert_n}, 8'h01);
    rd(3'd2, d); chk("R9 masked bit set", d, 8'h02);
    fan_m = 2'b01; fan_c = 2'b01; step(3);
    chk("R9 fan masked", {7'd0, alert_n}, 8'h01);
    fan_c = 2'b10; step(2);
    chk("R9 fan unmasked alert", {7'd0, alert_n}, 8'h00);
    fan_c = '0; rd(3'd0, d); chk("R2 summary fan", d, 8'h08);
    rd(3'd5, d); chk("R1 fan reg", d, 8'h03);
    gpio_c = 4'b1001; step(1); gpio_c = '0;
    rd(3'd0, d); chk("R2 summary gpio", d, 8'h10);
    rd(3'd6, d); chk("R1 gpio reg", d, 8'h09);
    rd(3'd6, d); rd(3'd5, d); chk("R1 fan emptied", d, 8'h00);
    rd(3'd7, d); chk("R1 unused addr", d, 8'h00);
    step(1); chk("R8 released after clears", {7'd0, alert_n}, 8'h01);
    ch_m = '0; fan_m = '0;
  endtask

  task automatic t_crit();
    shdn_en = 4'b0100; crit_c = 4'b0010; step(2);
    chk("R12 not enabled no shutdown", {7'd0, shutdown}, 8'h00);
    rd(3'd1, d); chk("R12 not enabled no bit", d, 8'h00);
    crit_c = 4'b0100; step(1);
    chk("R11 shutdown asserts", {7'd0, shutdown}, 8'h01);
    rd(3'd1, d); chk("R10 HWS with bit", d, 8'h84);
    rd(3'd0, d); chk("R2 summary crit", d, 8'h20);
    crit_c = '0; step(1);
    chk("R11 shutdown releases", {7'd0, shutdown}, 8'h00);
    rd(3'd1, d); chk("R11 latched bit stays", d, 8'h04);
    rd(3'd1, d); chk("R5 crit cleared", d, 8'h00);
    ch_m = 4'b0100; crit_c = 4'b0100; step(3);
    chk("R10 HWS no alert", {7'd0, alert_n}, 8'h01);
    rd(3'd1, d); chk("R10 HWS masked read", d, 8'h84);
    crit_c = '0; step(1); rd(3'd1, d); ch_m = '0; shdn_en = '0;
  endtask

  initial begin
    fork
      begin
        step(3); rst = 1'b0; step(1);
        t_reset(); t_high_sticky(); t_persist(); t_race();
        t_fault(); t_mask(); t_crit();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=00 expected=01");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule